// File: doc/BRIEF.md
# Control Endpoint Mode and Status Register

This block is the 8-bit mode and status register of a USB device's bidirectional control endpoint. It sits between the serial interface engine and the CPU I/O bus. The engine reports the arrival of SETUP, IN and OUT tokens, the start of a SETUP data packet, the start of the returned ACK packet, and the completion of a transaction with an ACK. Each of these arrives as a single-cycle strobe. The CPU reads the register to learn what happened. It writes the register to pick the endpoint's response mode and to clear the flags.

The register has five fields. The low nibble is a response-mode field that the CPU owns. Bit 4 is a handshake-done flag. Bit 5 flags an OUT token, bit 6 an IN token and bit 7 a SETUP token.

The SETUP flag has special rules. Only the engine can set it, and any CPU write clears it. A small window state machine keeps it forced high from the start of the SETUP data packet until the ACK begins, so an early clear by firmware is lost. The window machine has three states:
- `WIN_IDLE`: no SETUP in progress.
- `WIN_TOKEN`: a SETUP token has been seen and its data packet has not yet started.
- `WIN_HOLD`: the data packet has started and the flag is forced high.

Its transitions are:
- `WIN_IDLE`→`WIN_TOKEN` on a SETUP token.
- `WIN_TOKEN`→`WIN_HOLD` on the data-start strobe.
- `WIN_TOKEN`→`WIN_IDLE` on an IN or OUT token.
- `WIN_HOLD`→`WIN_IDLE` on the ACK-start strobe.

Top module: `ctl_ep_status_reg`

## Requirements
- R1: After reset every bit of the register reads 0, and the window machine is in `WIN_IDLE`.
- R2: A CPU write loads bits 3..0 from `cpu_wdata[3:0]`. The new value reads back from the cycle after the write.
- R3: `sie_ack_done` sets bit 4. If a CPU write clears bit 4 in the same cycle, the set wins.
- R4: For bits 4, 5 and 6, a CPU write with a 0 in that bit position clears the bit, and a 1 leaves it unchanged.
- R5: A token strobe sets its own flag and clears the other two token flags. The flags are bit 5 for OUT, bit 6 for IN and bit 7 for SETUP. If a CPU clear of the same bit happens in the same cycle, the set wins.
- R6: Any CPU write clears bit 7, whatever the value of `cpu_wdata[7]`, unless a SETUP token arrives in the same cycle.
- R7: Bit 7 is forced to 1 in every cycle from the `sie_setup_data_start` strobe that follows a SETUP token up to, but not including, the `sie_ack_sent` strobe. CPU writes and IN or OUT tokens do not clear it during that window. A write in the `sie_ack_sent` cycle or later clears it.
- R8: `rdata` shows the whole register while `cpu_rd` is 1, and reads 0 while `cpu_rd` is 0.
- R9: The window machine follows the transitions listed above. A data-start strobe outside `WIN_TOKEN` does not force bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sie_setup_tok | input | 1 | SETUP token received strobe |
| sie_in_tok | input | 1 | IN token received strobe |
| sie_out_tok | input | 1 | OUT token received strobe |
| sie_setup_data_start | input | 1 | Start of SETUP data packet strobe |
| sie_ack_sent | input | 1 | Start of returned ACK packet strobe |
| sie_ack_done | input | 1 | Transaction finished with ACK strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read enable |
| cpu_wdata | input | 8 | CPU write data |
| rdata | output | 8 | Register read data |

## Verification
The assertions check, on every cycle, the following rules:
- an engine set beats a simultaneous clear on each flag;
- a lone clear takes effect;
- the SETUP flag stays high after every cycle of the forced window;
- the mode nibble tracks the last write;
- the hold state always returns to idle on the ACK-start strobe.

Only the bench's scenarios can show the rest. This covers that a token clears its sibling flags, that a write with bit 7 set still clears SETUP, and that a clear attempted inside the window is lost while one issued at or after the ACK start takes effect. It also covers that an aborted SETUP leaves a later data-start strobe harmless. The bench sweeps all 256 write values against preloaded flag states.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

    localparam int REG_W     = 8;
    localparam int MODE_W    = 4;
    localparam int ACK_BIT   = 4;
    localparam int OUT_BIT   = 5;
    localparam int IN_BIT    = 6;
    localparam int SETUP_BIT = 7;
    localparam int FLAG_CNT  = 3;   // sticky flags handled generically: ack, out, in

    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,
        WIN_TOKEN = 2'd1,
        WIN_HOLD  = 2'd2
    } win_state_t;

endpackage

// File: rtl/ctl_ep_setup_window.sv
module ctl_ep_setup_window
    import ctl_ep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic setup_tok,
    input  logic in_tok,
    input  logic out_tok,
    input  logic data_start,
    input  logic ack_sent,
    output logic hold_now
);

    win_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        hold_now = 1'b0;
        unique case (state_q)
            WIN_IDLE: begin
                if (setup_tok) state_d = WIN_TOKEN;
            end
            WIN_TOKEN: begin
                if (data_start) begin
                    state_d  = WIN_HOLD;
                    hold_now = 1'b1;
                end else if (in_tok || out_tok) begin
                    state_d = WIN_IDLE;
                end
            end
            WIN_HOLD: begin
                if (ack_sent) state_d = WIN_IDLE;
                else          hold_now = 1'b1;
            end
            default: state_d = WIN_IDLE;
        endcase
    end

    // R9: the hold state always ends on the ACK-start strobe
    assert_hold_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_HOLD && ack_sent) |=> (state_q == WIN_IDLE));

    // R9: entry to hold only from the token state on data start
    assert_hold_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_IDLE) |=> (state_q != WIN_HOLD));

endmodule

// File: rtl/ctl_ep_mode_field.sv
module ctl_ep_mode_field #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mode_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mode_q <= '0;
        else if (wr) mode_q <= wdata;
    end

    // R2: mode follows the last write
    assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (mode_q == $past(wdata)));

    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mode_q));

endmodule

// File: rtl/ctl_ep_flag_bit.sv
module ctl_ep_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    // R3 / R5: set beats a clear in the same cycle
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);

    // R4 / R6: a lone clear takes effect
    assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);

endmodule

// File: rtl/ctl_ep_status_reg.sv
module ctl_ep_status_reg
    import ctl_ep_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sie_setup_tok,
    input  logic        sie_in_tok,
    input  logic        sie_out_tok,
    input  logic        sie_setup_data_start,
    input  logic        sie_ack_sent,
    input  logic        sie_ack_done,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  rdata
);

    logic              hold_now;
    logic [MODE_W-1:0] mode_q;
    logic [FLAG_CNT-1:0] flag_set, flag_clr, flag_q;
    logic              setup_q;
    logic [REG_W-1:0]  reg_val;

    ctl_ep_setup_window win_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .setup_tok  (sie_setup_tok),
        .in_tok     (sie_in_tok),
        .out_tok    (sie_out_tok),
        .data_start (sie_setup_data_start),
        .ack_sent   (sie_ack_sent),
        .hold_now   (hold_now)
    );

    ctl_ep_mode_field #(.W(MODE_W)) mode_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cpu_wr),
        .wdata  (cpu_wdata[MODE_W-1:0]),
        .mode_q (mode_q)
    );

    // Index 0 = ack, 1 = out, 2 = in; register bit = ACK_BIT + index.
    always_comb begin
        flag_set[0] = sie_ack_done;
        flag_set[1] = sie_out_tok;
        flag_set[2] = sie_in_tok;
        flag_clr[0] = cpu_wr && !cpu_wdata[ACK_BIT];
        flag_clr[1] = (cpu_wr && !cpu_wdata[OUT_BIT]) || sie_in_tok  || sie_setup_tok;
        flag_clr[2] = (cpu_wr && !cpu_wdata[IN_BIT])  || sie_out_tok || sie_setup_tok;
    end

    for (genvar g = 0; g < FLAG_CNT; g++) begin : g_flag
        ctl_ep_flag_bit flag_i (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (flag_set[g]),
            .clr   (flag_clr[g]),
            .q     (flag_q[g])
        );
    end

    ctl_ep_flag_bit setup_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (sie_setup_tok || hold_now),
        .clr   (cpu_wr || sie_in_tok || sie_out_tok),
        .q     (setup_q)
    );

    assign reg_val = {setup_q, flag_q, mode_q};
    assign rdata   = cpu_rd ? reg_val : '0;

    // R7: inside the forced window the SETUP flag reads high next cycle
    assert_setup_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_now |=> reg_val[SETUP_BIT]);

    // R6: a write with no SETUP source clears the flag
    assert_setup_write_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !sie_setup_tok && !hold_now) |=> !reg_val[SETUP_BIT]);

endmodule

// File: tb/ctl_ep_status_reg_tb.sv
module ctl_ep_status_reg_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st = 0, it = 0, ot = 0, ds = 0, as_ = 0, ad = 0, wr = 0, rd = 1;
    logic [7:0] wd = '0;
    logic [7:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [7:0] exp_reg = '0;
    int bstate = 0;   // 0 idle, 1 token seen, 2 forced window

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_ep_status_reg dut_i (
        .clk(clk), .rst_n(rst_n),
        .sie_setup_tok(st), .sie_in_tok(it), .sie_out_tok(ot),
        .sie_setup_data_start(ds), .sie_ack_sent(as_), .sie_ack_done(ad),
        .cpu_wr(wr), .cpu_rd(rd), .cpu_wdata(wd), .rdata(rdata)
    );

    function automatic logic [7:0] model(input logic [7:0] cur, input logic w,
        input logic [7:0] d, input logic s, input logic i, input logic o,
        input logic a, input logic hold);
        logic [7:0] n;
        n = cur;
        if (w) begin
            n[3:0] = d[3:0];
            n[4] = n[4] & d[4];
            n[5] = n[5] & d[5];
            n[6] = n[6] & d[6];
            n[7] = 1'b0;
        end
        if (s || i || o) n[7:5] = 3'b000;
        if (a) n[4] = 1'b1;
        if (o) n[5] = 1'b1;
        if (i) n[6] = 1'b1;
        if (s || hold) n[7] = 1'b1;
        return n;
    endfunction

    task automatic check(input string tag, input logic [7:0] expv);
        n_cmp++;
        if (rdata !== expv) begin
            n_bad++;
            $display("FAIL %s: rdata=%02h expected=%02h", tag, rdata, expv);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] d, input logic s,
        input logic i, input logic o, input logic dstart, input logic asent,
        input logic adone);
        logic hold;
        @(negedge clk);
        wr = w; wd = d; st = s; it = i; ot = o; ds = dstart; as_ = asent; ad = adone;
        hold = (bstate == 2 && !asent) || (bstate == 1 && dstart);
        exp_reg = model(exp_reg, w, d, s, i, o, adone, hold);
        case (bstate)
            0: if (s) bstate = 1;
            1: if (dstart) bstate = 2; else if (i || o) bstate = 0;
            2: if (asent) bstate = 0;
            default: bstate = 0;
        endcase
        @(negedge clk);
        wr = 0; st = 0; it = 0; ot = 0; ds = 0; as_ = 0; ad = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", 8'h00);

        // R8: read gating
        rd = 0; #1;
        check("R8 rdata zero when not reading", 8'h00);
        rd = 1;

        // Sweep: preload flags with a token/ack pattern, then write every value (R2 R4 R5 R6)
        for (int v = 0; v < 256; v++) begin
            step(0, 8'h00, v[1:0] == 2'd3, v[1:0] == 2'd2, v[1:0] == 2'd1, 0, 0, v[2]);
            check("R5 token preload", exp_reg);
            // abort any token-state so sweep writes stay outside the window
            if (bstate == 1) begin
                step(0, 8'h00, 0, 0, 1, 0, 0, 0);
                check("R9 abort via OUT", exp_reg);
            end
            step(1, v[7:0], 0, 0, 0, 0, 0, 0);
            check("R2 R4 R6 sweep write", exp_reg);
            if (rdata[7] !== 1'b0) begin
                n_cmp++; n_bad++;
                $display("FAIL R6: bit7=%b expected=0", rdata[7]);
            end
        end

        // R3: ack set wins over same-cycle clear
        step(1, 8'h00, 0, 0, 0, 0, 0, 0);
        step(1, 8'h00, 0, 0, 0, 0, 0, 1);
        check("R3 ack set beats clear", 8'h10);
        // R4: write 1 keeps, write 0 clears
        step(1, 8'h1A, 0, 0, 0, 0, 0, 0);
        check("R4 write one keeps ack", 8'h1A);
        step(1, 8'h05, 0, 0, 0, 0, 0, 0);
        check("R4 write zero clears ack", 8'h05);
        // R5: OUT set wins over clear, IN clears OUT
        step(1, 8'h00, 0, 0, 1, 0, 0, 0);
        check("R5 out set beats clear", 8'h20);
        step(0, 8'h00, 0, 1, 0, 0, 0, 0);
        check("R5 in clears out", 8'h40);
        // R6: SETUP set wins over write; write with bit7=1 still clears
        step(1, 8'hFF, 1, 0, 0, 0, 0, 0);
        check("R6 setup set beats write", 8'h8F);
        step(0, 8'h00, 0, 1, 0, 0, 0, 0);   // leave token state (R9)
        check("R5 in clears setup", 8'h4F);
        step(0, 8'h00, 1, 0, 0, 0, 0, 0);
        step(1, 8'h80, 0, 0, 0, 0, 0, 0);
        check("R6 write with bit7 set clears", 8'h00);
        // R9: token state still pending; data start now forces bit 7
        step(0, 8'h00, 0, 0, 0, 1, 0, 0);
        check("R7 forced high from data start", 8'h80);
        step(1, 8'h03, 0, 0, 0, 0, 0, 0);
        check("R7 clear in window ignored", 8'h83);
        step(0, 8'h00, 0, 0, 1, 0, 0, 0);
        check("R7 OUT token in window keeps setup", 8'hA3);
        step(1, 8'h00, 0, 0, 0, 0, 0, 0);
        check("R7 second clear in window ignored", 8'h80);
        step(1, 8'h00, 0, 0, 0, 0, 1, 0);
        check("R7 clear at ack start takes effect", 8'h00);

        // Clear before data start, then data start forces it back high
        step(0, 8'h00, 1, 0, 0, 0, 0, 0);
        step(1, 8'h00, 0, 0, 0, 0, 0, 0);
        check("R6 clear before window", 8'h00);
        step(0, 8'h00, 0, 0, 0, 1, 0, 0);
        check("R7 data start re-forces setup", 8'h80);
        step(0, 8'h00, 0, 0, 0, 0, 1, 1);
        check("R7 ack ends window", 8'h90);
        step(1, 8'h10, 0, 0, 0, 0, 0, 0);
        check("R7 clear after ack takes effect", 8'h10);

        // R9: aborted SETUP makes a later data start harmless
        step(0, 8'h00, 1, 0, 0, 0, 0, 0);
        step(0, 8'h00, 0, 1, 0, 0, 0, 0);
        check("R9 abort by IN", 8'h50);
        step(0, 8'h00, 0, 0, 0, 1, 0, 0);
        check("R9 stray data start no force", 8'h50);
        step(1, 8'h00, 0, 0, 0, 0, 0, 0);
        check("R9 write after abort", exp_reg);

        rd = 0; #1;
        check("R8 rdata zero at end", 8'h00);
        rd = 1;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule